// File: doc/BRIEF.md
# Buck Converter Protection and Hiccup Manager

This block is the digital protection core of one output channel of a multi-phase buck regulator. It receives comparator results that have already been converted to logic levels: feedback above a first and a second over-voltage level, feedback back below the over-voltage release level, feedback below the under-voltage level, a current-limit flag per phase, an over-temperature flag, and die-temperature hot and cool flags. From the start-up sequencer it takes two level indications: soft start has begun, and the power-good delay has expired. It also takes a one-cycle strobe per switching period. It filters each fault over time and decides how the power stage is driven. It then drives a power-good pull-down, reports the active fault on a one-hot flag vector, and issues a one-cycle restart request when a hiccup off-time or a thermal shutdown ends.

Over-voltage is recoverable at two levels. The first level turns on every low-side switch and keeps negative-current limiting. The second level does the same with negative-current limiting disabled. Both return to normal operation without a restart once feedback falls below the release level. Under-voltage, over-current and over-temperature shut the stage off for a fault-specific multiple of the soft-start time, and a fresh start-up follows. Thermal shutdown puts every PWM output in high impedance and overrides everything else.

Top module: `buck_prot_mgr`

## Requirements
- R1: After reset, gate_mode_o is 0 (normal switching), pg_pull_low_o is 0, fault_flags_o is 0 and restart_o is 0.
- R2: With the late window open, ovl_cmp_i high for more than OV_DEB_CYC consecutive cycles sets gate_mode_o to 1 (all low-side on). It also sets neg_ilim_en_o to 1, pg_pull_low_o to 1 and fault_flags_o bit 0.
- R3: With the early window open, ovh_cmp_i high for more than OV_DEB_CYC consecutive cycles gives gate_mode_o 1 with neg_ilim_en_o 0 and fault_flags_o bit 1. This also applies when the first level has already tripped, which escalates it.
- R4: While either over-voltage level is active, ov_release_i high returns gate_mode_o to 0 on the next cycle. pg_pull_low_o is released, the flags clear, and no restart pulse is given.
- R5: With the late window open, uv_cmp_i high for more than UV_DEB_CYC cycles sets gate_mode_o to 2 (all off), pg_pull_low_o and fault_flags_o bit 2 for exactly 12×TSS_CYC cycles. restart_o is then high for one cycle as gate_mode_o returns to 0.
- R6: Over-current trips on the switching strobe on which every phase marked in phase_act_i has been in limit for more than OC_CYC consecutive strobes. Any strobe with an active phase out of limit resets the run, and inactive phases are ignored. The result is gate_mode_o 2 and flag bit 3 for 16×TSS_CYC cycles, then a restart pulse.
- R7: ot_cmp_i high for more than OT_DEB_CYC cycles in the early window gives gate_mode_o 2 and flag bit 4 for 8×TSS_CYC cycles. If ot_cmp_i is still high at the end, the off state holds without a restart until it falls. The restart pulse comes on the next cycle.
- R8: The second-level over-voltage, over-current and over-temperature checks run only while ss_begun_i is high. The first-level over-voltage and under-voltage checks run only while pgd_done_i is high.
- R9: During a hiccup off-time every detector is disarmed. Comparator activity then changes neither gate_mode_o nor fault_flags_o.
- R10: tsd_hot_i high for more than TSD_DEB_CYC cycles sets gate_mode_o to 3 (tri-state), pg_pull_low_o and fault_flags_o bit 5 from any state. tsd_cool_i high returns gate_mode_o to 0 with a one-cycle restart_o on the next cycle.
- R11: Priority is thermal shutdown, then the second over-voltage level, then the first, then under-voltage, over-current and over-temperature. fault_flags_o never has more than one bit set.
- R12: A comparator pulse lasting exactly the debounce length (OV_DEB_CYC, UV_DEB_CYC, OT_DEB_CYC or TSD_DEB_CYC cycles) causes no trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_begun_i | input | 1 | Soft start has begun (opens the early window) |
| pgd_done_i | input | 1 | Power-good delay expired (opens the late window) |
| sw_cycle_i | input | 1 | One-cycle strobe per switching period |
| ovl_cmp_i | input | 1 | Feedback above first over-voltage level |
| ovh_cmp_i | input | 1 | Feedback above second over-voltage level |
| ov_release_i | input | 1 | Feedback below over-voltage release level |
| uv_cmp_i | input | 1 | Feedback below under-voltage level |
| ocl_i | input | NPH | Per-phase current-limit flags |
| phase_act_i | input | NPH | Phases active in this channel |
| ot_cmp_i | input | 1 | Over-temperature flag |
| tsd_hot_i | input | 1 | Die above thermal shutdown point |
| tsd_cool_i | input | 1 | Die below recovery point |
| gate_mode_o | output | 2 | 0 normal, 1 all low-side on, 2 all off, 3 tri-state |
| neg_ilim_en_o | output | 1 | Low-side negative-current limiting enabled |
| pg_pull_low_o | output | 1 | Pull power-good low |
| fault_flags_o | output | 6 | One-hot: 0 OV1, 1 OV2, 2 UV, 3 OC, 4 OT, 5 TSD |
| restart_o | output | 1 | One-cycle request for a fresh start-up |

## Verification
A corrupted state register shows on gate_mode_o and fault_flags_o in the very next cycle, since both are decoded straight from it. A miscounting debounce or switching-cycle counter shifts the trip by exactly one cycle or one strobe. The bench samples one cycle before and one cycle after each expected trip to catch that shift. A faulty off-time counter changes the number of all-off cycles, which is counted to the cycle before the restart pulse is checked.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic [1:0] {
    GM_NORMAL   = 2'd0,
    GM_LS_ON    = 2'd1,
    GM_ALL_OFF  = 2'd2,
    GM_TRISTATE = 2'd3
  } gate_mode_e;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_OVP  = 3'd1,
    ST_HIC  = 3'd2,
    ST_COOL = 3'd3,
    ST_TSD  = 3'd4
  } prot_state_e;

  typedef enum logic [1:0] {
    CAUSE_UV = 2'd0,
    CAUSE_OC = 2'd1,
    CAUSE_OT = 2'd2
  } hic_cause_e;

  localparam int unsigned FLAG_W   = 6;
  localparam int unsigned FB_OVL   = 0;
  localparam int unsigned FB_OVH   = 1;
  localparam int unsigned FB_UV    = 2;
  localparam int unsigned FB_OC    = 3;
  localparam int unsigned FB_OT    = 4;
  localparam int unsigned FB_TSD   = 5;
endpackage

// File: rtl/bpm_debounce.sv
module bpm_debounce #(
  parameter int unsigned LEN = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic lvl_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!(arm_i && lvl_i)) begin
      run_cnt <= '0;
    end else if (run_cnt != CW'(LEN)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // trips on the first armed-and-high cycle after LEN such cycles
  assign trip_o = arm_i && lvl_i && (run_cnt == CW'(LEN));

  assert_trip_has_history_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> ($past(lvl_i) && $past(arm_i)));
endmodule

// File: rtl/bpm_oc_window.sv
module bpm_oc_window #(
  parameter int unsigned NPH    = 4,
  parameter int unsigned OC_CYC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm_i,
  input  logic           sw_cycle_i,
  input  logic [NPH-1:0] ocl_i,
  input  logic [NPH-1:0] phase_act_i,
  output logic           trip_o
);
  localparam int unsigned CW = $clog2(OC_CYC + 1);

  logic [NPH-1:0] ph_ok;
  logic           all_lim;
  logic [CW-1:0]  cyc_cnt;

  // a phase is satisfied when inactive or in limit
  for (genvar g = 0; g < NPH; g++) begin : g_phase
    assign ph_ok[g] = !phase_act_i[g] || ocl_i[g];
  end

  assign all_lim = (|phase_act_i) && (&ph_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
    end else if (!arm_i) begin
      cyc_cnt <= '0;
    end else if (sw_cycle_i) begin
      if (!all_lim)                    cyc_cnt <= '0;
      else if (cyc_cnt != CW'(OC_CYC)) cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  assign trip_o = arm_i && sw_cycle_i && all_lim && (cyc_cnt == CW'(OC_CYC));

  assert_oc_run_before_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> $past(arm_i));
endmodule

// File: rtl/bpm_hiccup_timer.sv
module bpm_hiccup_timer #(
  parameter int unsigned TSS_CYC = 200,
  parameter int unsigned MULT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              done_o
);
  localparam int unsigned TW = $clog2(TSS_CYC + 1);

  logic [TW-1:0]     tick;
  logic [MULT_W-1:0] mcnt;
  logic              last_tick;

  assign last_tick = (tick == TW'(TSS_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      tick <= '0;
      mcnt <= '0;
    end else if (last_tick) begin
      tick <= '0;
      mcnt <= mcnt + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign done_o = run_i && last_tick && (mcnt == mult_i - MULT_W'(1));

  assert_done_within_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(run_i));
endmodule

// File: rtl/buck_prot_mgr.sv
module buck_prot_mgr
  import bpm_pkg::*;
#(
  parameter int unsigned NPH         = 4,
  parameter int unsigned OV_DEB_CYC  = 125,
  parameter int unsigned UV_DEB_CYC  = 188,
  parameter int unsigned OT_DEB_CYC  = 20,
  parameter int unsigned TSD_DEB_CYC = 15,
  parameter int unsigned OC_CYC      = 8,
  parameter int unsigned TSS_CYC     = 200,
  parameter int unsigned UV_MULT     = 12,
  parameter int unsigned OC_MULT     = 16,
  parameter int unsigned OT_MULT     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_begun_i,
  input  logic              pgd_done_i,
  input  logic              sw_cycle_i,
  input  logic              ovl_cmp_i,
  input  logic              ovh_cmp_i,
  input  logic              ov_release_i,
  input  logic              uv_cmp_i,
  input  logic [NPH-1:0]    ocl_i,
  input  logic [NPH-1:0]    phase_act_i,
  input  logic              ot_cmp_i,
  input  logic              tsd_hot_i,
  input  logic              tsd_cool_i,
  output logic [1:0]        gate_mode_o,
  output logic              neg_ilim_en_o,
  output logic              pg_pull_low_o,
  output logic [FLAG_W-1:0] fault_flags_o,
  output logic              restart_o
);
  localparam int unsigned MAX_MULT = (UV_MULT > OC_MULT) ?
                                     ((UV_MULT > OT_MULT) ? UV_MULT : OT_MULT) :
                                     ((OC_MULT > OT_MULT) ? OC_MULT : OT_MULT);
  localparam int unsigned MULT_W = $clog2(MAX_MULT + 1);

  prot_state_e       st, st_nxt;
  hic_cause_e        cause, cause_nxt;
  logic              ovh_lvl, ovh_lvl_nxt;
  logic              restart_d;
  logic              live, arm_early, arm_late;
  logic              ovl_trip, ovh_trip, uv_trip, oc_trip, ot_trip, tsd_trip;
  logic              hic_done;
  logic [MULT_W-1:0] hic_mult;
  gate_mode_e        gm;

  assign live      = (st == ST_RUN) || (st == ST_OVP);
  assign arm_early = live && ss_begun_i;
  assign arm_late  = live && pgd_done_i;

  bpm_debounce #(.LEN(OV_DEB_CYC)) u_deb_ovl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_late),  .lvl_i(ovl_cmp_i), .trip_o(ovl_trip));
  bpm_debounce #(.LEN(OV_DEB_CYC)) u_deb_ovh (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_early), .lvl_i(ovh_cmp_i), .trip_o(ovh_trip));
  bpm_debounce #(.LEN(UV_DEB_CYC)) u_deb_uv (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_late),  .lvl_i(uv_cmp_i),  .trip_o(uv_trip));
  bpm_debounce #(.LEN(OT_DEB_CYC)) u_deb_ot (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_early), .lvl_i(ot_cmp_i),  .trip_o(ot_trip));
  bpm_debounce #(.LEN(TSD_DEB_CYC)) u_deb_tsd (
    .clk(clk), .rst_n(rst_n), .arm_i(1'b1),      .lvl_i(tsd_hot_i), .trip_o(tsd_trip));

  bpm_oc_window #(.NPH(NPH), .OC_CYC(OC_CYC)) u_oc (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_early), .sw_cycle_i(sw_cycle_i),
    .ocl_i(ocl_i), .phase_act_i(phase_act_i), .trip_o(oc_trip));

  always_comb begin
    case (cause)
      CAUSE_UV: hic_mult = MULT_W'(UV_MULT);
      CAUSE_OC: hic_mult = MULT_W'(OC_MULT);
      default:  hic_mult = MULT_W'(OT_MULT);
    endcase
  end

  bpm_hiccup_timer #(.TSS_CYC(TSS_CYC), .MULT_W(MULT_W)) u_hic (
    .clk(clk), .rst_n(rst_n), .run_i(st == ST_HIC), .mult_i(hic_mult), .done_o(hic_done));

  // next-state selection; thermal shutdown outranks every state
  always_comb begin
    st_nxt      = st;
    cause_nxt   = cause;
    ovh_lvl_nxt = ovh_lvl;
    restart_d   = 1'b0;
    if (tsd_trip && st != ST_TSD) begin
      st_nxt = ST_TSD;
    end else begin
      case (st)
        ST_RUN: begin
          if (ovh_trip) begin
            st_nxt = ST_OVP; ovh_lvl_nxt = 1'b1;
          end else if (ovl_trip) begin
            st_nxt = ST_OVP; ovh_lvl_nxt = 1'b0;
          end else if (uv_trip) begin
            st_nxt = ST_HIC; cause_nxt = CAUSE_UV;
          end else if (oc_trip) begin
            st_nxt = ST_HIC; cause_nxt = CAUSE_OC;
          end else if (ot_trip) begin
            st_nxt = ST_HIC; cause_nxt = CAUSE_OT;
          end
        end
        ST_OVP: begin
          if (ovh_trip && !ovh_lvl) ovh_lvl_nxt = 1'b1;
          else if (ov_release_i)    st_nxt = ST_RUN;
        end
        ST_HIC: begin
          if (hic_done) begin
            if (cause == CAUSE_OT && ot_cmp_i) begin
              st_nxt = ST_COOL;
            end else begin
              st_nxt = ST_RUN; restart_d = 1'b1;
            end
          end
        end
        ST_COOL: begin
          if (!ot_cmp_i) begin
            st_nxt = ST_RUN; restart_d = 1'b1;
          end
        end
        ST_TSD: begin
          if (tsd_cool_i) begin
            st_nxt = ST_RUN; restart_d = 1'b1;
          end
        end
        default: st_nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_RUN;
      cause     <= CAUSE_UV;
      ovh_lvl   <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      st        <= st_nxt;
      cause     <= cause_nxt;
      ovh_lvl   <= ovh_lvl_nxt;
      restart_o <= restart_d;
    end
  end

  // output decode from state
  always_comb begin
    gm            = GM_NORMAL;
    fault_flags_o = '0;
    case (st)
      ST_OVP: begin
        gm = GM_LS_ON;
        fault_flags_o[ovh_lvl ? FB_OVH : FB_OVL] = 1'b1;
      end
      ST_HIC, ST_COOL: begin
        gm = GM_ALL_OFF;
        case (cause)
          CAUSE_UV: fault_flags_o[FB_UV] = 1'b1;
          CAUSE_OC: fault_flags_o[FB_OC] = 1'b1;
          default:  fault_flags_o[FB_OT] = 1'b1;
        endcase
      end
      ST_TSD: begin
        gm = GM_TRISTATE;
        fault_flags_o[FB_TSD] = 1'b1;
      end
      default: ;
    endcase
  end

  assign gate_mode_o   = gm;
  assign pg_pull_low_o = (st != ST_RUN);
  assign neg_ilim_en_o = (st == ST_OVP) && !ovh_lvl;

  assert_flags_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_flags_o));
  assert_pg_low_on_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_flags_o) |-> pg_pull_low_o);
  assert_no_nil_at_ovh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flags_o[FB_OVH] |-> !neg_ilim_en_o);
  assert_restart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);
  assert_release_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_mode_o) == 2'd1 && gate_mode_o == 2'd0) |-> !restart_o);
  assert_tsd_tristate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_trip && st != ST_TSD) |=> (gate_mode_o == 2'd3));
endmodule

// File: tb/buck_prot_mgr_bench.sv
module buck_prot_mgr_bench;
  localparam int NPH = 4;
  localparam int OV_DEB = 125;
  localparam int UV_DEB = 188;
  localparam int OT_DEB = 20;
  localparam int TSD_DEB = 15;
  localparam int OC_N = 8;
  localparam int TSS = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_begun = 1'b1, pgd_done = 1'b1, sw_cycle = 1'b0;
  logic ovl = 1'b0, ovh = 1'b0, ov_rel = 1'b0, uv = 1'b0;
  logic [NPH-1:0] ocl = '0, pact = '1;
  logic ot = 1'b0, tsd_hot = 1'b0, tsd_cool = 1'b0;
  logic [1:0] gate;
  logic nil, pgl, restart;
  logic [5:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  buck_prot_mgr #(
    .NPH(NPH), .OV_DEB_CYC(OV_DEB), .UV_DEB_CYC(UV_DEB), .OT_DEB_CYC(OT_DEB),
    .TSD_DEB_CYC(TSD_DEB), .OC_CYC(OC_N), .TSS_CYC(TSS),
    .UV_MULT(12), .OC_MULT(16), .OT_MULT(8)
  ) u_buck_prot_mgr (
    .clk(clk), .rst_n(rst_n), .ss_begun_i(ss_begun), .pgd_done_i(pgd_done),
    .sw_cycle_i(sw_cycle), .ovl_cmp_i(ovl), .ovh_cmp_i(ovh), .ov_release_i(ov_rel),
    .uv_cmp_i(uv), .ocl_i(ocl), .phase_act_i(pact), .ot_cmp_i(ot),
    .tsd_hot_i(tsd_hot), .tsd_cool_i(tsd_cool), .gate_mode_o(gate),
    .neg_ilim_en_o(nil), .pg_pull_low_o(pgl), .fault_flags_o(flags), .restart_o(restart));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_off(input string req, input int exp);
    int n = 0;
    while (gate == 2'd2 && n < 20000) begin
      n++;
      step(1);
    end
    check(req, "all-off cycles", n, exp);
    check(req, "restart pulse", int'(restart), 1);
    check(req, "gate after restart", int'(gate), 0);
    step(1);
    check(req, "restart width", int'(restart), 0);
  endtask

  task automatic sw_pulse(input logic [NPH-1:0] lim);
    ocl = lim;
    sw_cycle = 1'b1;
    step(1);
    sw_cycle = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "gate", int'(gate), 0);
    check("R1", "pg pull", int'(pgl), 0);
    check("R1", "flags", int'(flags), 0);
    check("R1", "restart", int'(restart), 0);
  endtask

  task automatic t_ov_levels;
    ovl = 1'b1; step(OV_DEB);           // exactly the debounce length: R12
    check("R12", "gate after short OV1", int'(gate), 0);
    ovl = 1'b0; step(2);
    check("R12", "gate after OV1 glitch", int'(gate), 0);
    ovl = 1'b1; step(OV_DEB);
    check("R2", "gate before OV1 trip", int'(gate), 0);
    step(1);
    check("R2", "gate OV1", int'(gate), 1);
    check("R2", "neg ilim OV1", int'(nil), 1);
    check("R2", "pg OV1", int'(pgl), 1);
    check("R2", "flags OV1", int'(flags), 1);
    ovh = 1'b1; step(OV_DEB);
    check("R3", "flags before escalate", int'(flags), 1);
    step(1);
    check("R3", "flags OV2", int'(flags), 2);
    check("R3", "gate OV2", int'(gate), 1);
    check("R3", "neg ilim OV2", int'(nil), 0);
    ovh = 1'b0; ovl = 1'b0; ov_rel = 1'b1; step(1);
    check("R4", "gate after release", int'(gate), 0);
    check("R4", "flags after release", int'(flags), 0);
    check("R4", "pg after release", int'(pgl), 0);
    check("R4", "no restart", int'(restart), 0);
    ov_rel = 1'b0; step(2);
  endtask

  task automatic t_priority;
    ovl = 1'b1; ovh = 1'b1; step(OV_DEB + 1);
    check("R11", "OV2 wins over OV1", int'(flags), 2);
    tsd_hot = 1'b1; step(TSD_DEB);
    check("R12", "TSD not yet", int'(gate), 1);
    step(1);
    check("R10", "gate TSD", int'(gate), 3);
    check("R11", "TSD wins over OV2", int'(flags), 32);
    check("R10", "pg TSD", int'(pgl), 1);
    ovl = 1'b0; ovh = 1'b0; tsd_hot = 1'b0; step(5);
    check("R10", "TSD holds until cool", int'(gate), 3);
    tsd_cool = 1'b1; step(1);
    tsd_cool = 1'b0;
    check("R10", "gate after cool", int'(gate), 0);
    check("R10", "restart after cool", int'(restart), 1);
    step(1);
    check("R10", "restart width", int'(restart), 0);
  endtask

  task automatic t_uv;
    uv = 1'b1; step(UV_DEB);
    check("R5", "gate before UV trip", int'(gate), 0);
    step(1);
    check("R5", "gate UV", int'(gate), 2);
    check("R5", "flags UV", int'(flags), 4);
    uv = 1'b0;
    ovh = 1'b1; tsd_hot = 1'b0; step(300);    // disarmed during off-time: R9
    check("R9", "gate with OV2 in hiccup", int'(gate), 2);
    check("R9", "flags with OV2 in hiccup", int'(flags), 4);
    ovh = 1'b0;
    count_off("R5", 12 * TSS - 300);
  endtask

  task automatic t_oc;
    pact = 4'b0111;
    for (int i = 0; i < 8; i++) begin sw_pulse(4'b0111); step(4); end
    sw_pulse(4'b0101); step(4);             // one active phase out of limit resets
    for (int i = 0; i < 8; i++) begin sw_pulse(4'b0111); step(4); end
    check("R6", "gate after reset run of 8", int'(gate), 0);
    sw_pulse(4'b0111);
    check("R6", "gate OC", int'(gate), 2);
    check("R6", "flags OC", int'(flags), 8);
    ocl = '0;
    count_off("R6", 16 * TSS);
    pact = '1;
  endtask

  task automatic t_ot;
    ot = 1'b1; step(OT_DEB);
    check("R12", "OT not yet", int'(gate), 0);
    step(1);
    check("R7", "gate OT", int'(gate), 2);
    check("R7", "flags OT", int'(flags), 16);
    step(99);
    ot = 1'b0;
    count_off("R7", 8 * TSS - 99);
    ot = 1'b1; step(OT_DEB + 1);
    check("R7", "gate OT again", int'(gate), 2);
    step(8 * TSS);
    check("R7", "still off while hot", int'(gate), 2);
    check("R7", "flags while hot", int'(flags), 16);
    check("R7", "no restart while hot", int'(restart), 0);
    step(50);
    ot = 1'b0; step(1);
    check("R7", "gate after cool", int'(gate), 0);
    check("R7", "restart after cool", int'(restart), 1);
    step(2);
  endtask

  task automatic t_window;
    pgd_done = 1'b0;
    uv = 1'b1; ovl = 1'b1; step(UV_DEB + 20);
    check("R8", "UV/OV1 before PG delay", int'(gate), 0);
    uv = 1'b0; ovl = 1'b0;
    ss_begun = 1'b0; ovh = 1'b1; step(OV_DEB + 20);
    check("R8", "OV2 before soft start", int'(gate), 0);
    ss_begun = 1'b1; step(OV_DEB);
    check("R8", "OV2 debounce from soft start", int'(gate), 0);
    step(1);
    check("R8", "OV2 armed at soft start", int'(flags), 2);
    ovh = 1'b0; ov_rel = 1'b1; step(1);
    ov_rel = 1'b0; pgd_done = 1'b1; step(2);
    check("R8", "gate after window test", int'(gate), 0);
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_ov_levels();
    t_priority();
    t_uv();
    t_oc();
    t_ot();
    t_window();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule